// File: doc/BRIEF.md
# Eight-Bit Port Controller with Clock-Out Pin

This block is a general-purpose I/O port that sits on a small CPU register bus. Each of its eight pins can be set as an input or an output. An output pin drives a value held in a data register. The block drives per-pin output values and output enables toward the pads. It takes in the raw pad levels and passes them through a synchronizer before the read path uses them.

One pin, bit 6, works differently from the rest. When its direction bit is set, it drives a system clock signal instead of register data. A read of bit 6 always returns the synchronized pad level, whatever its direction bit says. The direction register cannot be read back, and software sees zeros there. Bus reads are registered, so read data is valid one cycle after the strobe.

Top module: `clkpin_port`

## Requirements
- R1: After reset, every direction bit is 0, so all output enables are low, every data bit is 0 and read data is 0.
- R2: A write to address 1 loads the direction register. Bit i at 1 raises `pin_oe[i]`, and bit i at 0 lowers it.
- R3: A read of address 1 returns 8'h00, whatever the direction register holds.
- R4: A write to address 0 loads data bits 0–5 and 7, and `pin_out[i]` then shows the written bit for each of those pins.
- R5: A read of address 0 returns the stored data bit for each pin other than bit 6 whose direction bit is 1, whatever that pin's level is.
- R6: A read of address 0 returns the synchronized pad level for each pin whose direction bit is 0. A pad change is not seen by a read strobe sampled on the first rising edge after the change, and is seen once two rising edges have passed.
- R7: Bit 6 of an address-0 read always returns the synchronized level of pad 6, even when its direction bit is 1. Writes to data bit 6 have no effect on that pin's output.
- R8: With direction bit 6 at 1, `pin_out[6]` follows `clk_src` and `pin_oe[6]` is high. With direction bit 6 at 0, `pin_out[6]` is 0.
- R9: `bus_rdata` changes only on the cycle after a read strobe, and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| clk_src | input | 1 | System clock to drive out on pin 6 |
| pin_in | input | 8 | Raw pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The checker samples `clk_src` and the output paths only at the rising clock edge. It also assumes that bus strobes and pad levels move only between edges. The bench therefore changes all inputs on the falling edge, and it drives `clk_src` as a slow data level rather than as a free-running clock. The checker further assumes that a read and a write never arrive in the same cycle, and no stimulus task ever raises both strobes together.

// File: rtl/clkpin_pkg.sv
`timescale 1ns/1ps
package clkpin_pkg;
  localparam int unsigned DEF_WIDTH   = 8;
  localparam int unsigned DEF_CLK_BIT = 6;
  localparam int unsigned DEF_SYNC    = 2;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/clkpin_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer, one chain per pin.
module clkpin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkpin_regs.sv
`timescale 1ns/1ps
// Direction and data registers. The clock-out bit of the data register
// is masked on write so it stays at its reset value.
module clkpin_regs #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_data,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q
);
  localparam logic [WIDTH-1:0] DATA_WMASK = ~(WIDTH'(1) << CLK_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= wdata & DATA_WMASK;
  end
endmodule

// File: rtl/clkpin_outsel.sv
`timescale 1ns/1ps
// Per-pin output value selection; the clock bit swaps in clk_src.
module clkpin_outsel #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic             clk_src,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == CLK_BIT) begin : g_clk
      assign pin_out[i] = dir_q[i] ? clk_src : data_q[i];
    end else begin : g_gp
      assign pin_out[i] = data_q[i];
    end
  end

  assign pin_oe = dir_q;
endmodule

// File: rtl/clkpin_rdpath.sv
`timescale 1ns/1ps
// Read-data composition and the registered read port.
module clkpin_rdpath
  import clkpin_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_evt,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] pin_lvl,
  output logic [WIDTH-1:0] rdata
);
  function automatic logic [WIDTH-1:0] port_view(
    input logic [WIDTH-1:0] dir,
    input logic [WIDTH-1:0] data,
    input logic [WIDTH-1:0] pin
  );
    logic [WIDTH-1:0] v;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == CLK_BIT) v[i] = pin[i];
      else              v[i] = dir[i] ? data[i] : pin[i];
    end
    return v;
  endfunction

  logic [WIDTH-1:0] rd_next;

  always_comb begin
    if (sel == SEL_DIR) rd_next = '0;
    else                rd_next = port_view(dir_q, data_q, pin_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_evt) rdata <= rd_next;
  end
endmodule

// File: rtl/clkpin_port.sv
`timescale 1ns/1ps
module clkpin_port
  import clkpin_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned CLK_BIT     = DEF_CLK_BIT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             clk_src,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  reg_sel_e         sel;
  logic             wr_dir_evt;
  logic             wr_data_evt;
  logic             rd_evt;
  logic [WIDTH-1:0] sync_lvl;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;

  assign sel         = reg_sel_e'(bus_addr);
  assign wr_dir_evt  = bus_wr && (sel == SEL_DIR);
  assign wr_data_evt = bus_wr && (sel == SEL_DATA);
  assign rd_evt      = bus_rd;

  clkpin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  clkpin_regs #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir_evt), .wr_data(wr_data_evt),
    .wdata(bus_wdata), .dir_q(dir_q), .data_q(data_q)
  );

  clkpin_outsel #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_outsel (
    .dir_q(dir_q), .data_q(data_q), .clk_src(clk_src),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  clkpin_rdpath #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .sel(sel), .dir_q(dir_q),
    .data_q(data_q), .pin_lvl(sync_lvl), .rdata(bus_rdata)
  );
endmodule

// File: rtl/clkpin_port_chk.sv
`timescale 1ns/1ps
module clkpin_port_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic             clk_src,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] sync_lvl
);
  localparam logic [WIDTH-1:0] NCLK = ~(WIDTH'(1) << CLK_BIT);

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> (pin_oe == $past(bus_wdata)));

  // R3
  dir_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr) |=> (bus_rdata == '0));

  // R4
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> ((pin_out & NCLK) == ($past(bus_wdata) & NCLK)));

  // R5
  out_read_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && !bus_wr) |=>
      (((bus_rdata ^ $past(pin_out)) & $past(pin_oe) & NCLK) == '0));

  // R6
  in_read_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |=>
      (((bus_rdata ^ $past(sync_lvl)) & ~$past(pin_oe) & NCLK) == '0));

  // R7
  clkbit_read_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |=> (bus_rdata[CLK_BIT] == $past(sync_lvl[CLK_BIT])));

  // R8
  clk_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[CLK_BIT] |-> (pin_out[CLK_BIT] == clk_src));

  // R8
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[CLK_BIT] |-> (pin_out[CLK_BIT] == 1'b0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind clkpin_port clkpin_port_chk #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .clk_src(clk_src), .pin_out(pin_out), .pin_oe(pin_oe), .sync_lvl(sync_lvl)
);

// File: tb/clkpin_port_tb.sv
`timescale 1ns/1ps
module clkpin_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       clk_src = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  clkpin_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_src(clk_src), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe after reset", pin_oe, 8'h00);
    chk("R1 out after reset", pin_out, 8'h00);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    read_reg(1'b0, v);
    chk("R6 R7 input read after reset", v, 8'h5A);
    read_reg(1'b1, v);
    chk("R3 dir read after reset", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    write_reg(1'b1, 8'hBF);
    chk("R2 oe pattern BF", pin_oe, 8'hBF);
    read_reg(1'b1, v);
    chk("R3 dir read is zero", v, 8'h00);
    write_reg(1'b1, 8'h21);
    chk("R2 oe pattern 21", pin_oe, 8'h21);
  endtask

  task automatic t_data();
    logic [7:0] v;
    write_reg(1'b1, 8'hBF);
    write_reg(1'b0, 8'hFF);
    chk("R4 R7 out ignores bit6 write", pin_out, 8'hBF);
    set_pins(8'h00);
    read_reg(1'b0, v);
    chk("R5 latched over low pins", v, 8'hBF);
    set_pins(8'hFF);
    read_reg(1'b0, v);
    chk("R5 R7 latched plus pin6", v, 8'hFF);
    write_reg(1'b0, 8'h3C);
    chk("R4 out pattern 3C", pin_out, 8'h3C);
    set_pins(8'hC3);
    read_reg(1'b0, v);
    chk("R5 latched over opposite pins", v, 8'h7C);
  endtask

  task automatic t_mixed();
    logic [7:0] v;
    write_reg(1'b1, 8'h0F);
    write_reg(1'b0, 8'h05);
    set_pins(8'hA0);
    read_reg(1'b0, v);
    chk("R5 R6 mixed directions", v, 8'hA5);
  endtask

  task automatic t_clk();
    logic [7:0] v;
    write_reg(1'b1, 8'h40);
    write_reg(1'b0, 8'h00);
    @(negedge clk); clk_src = 1'b1; #1;
    chk("R8 clk out high", {7'b0, pin_out[6]}, 8'h01);
    chk("R8 clk oe", {7'b0, pin_oe[6]}, 8'h01);
    @(negedge clk); clk_src = 1'b0; #1;
    chk("R8 clk out low", {7'b0, pin_out[6]}, 8'h00);
    set_pins(8'h40);
    read_reg(1'b0, v);
    chk("R7 bit6 pin high while output", v, 8'h40);
    set_pins(8'h00);
    read_reg(1'b0, v);
    chk("R7 bit6 pin low while output", v, 8'h00);
    write_reg(1'b1, 8'h00);
    @(negedge clk); clk_src = 1'b1; #1;
    chk("R8 clk not driven when input", {7'b0, pin_out[6]}, 8'h00);
    clk_src = 1'b0;
  endtask

  task automatic t_latency();
    logic [7:0] v;
    write_reg(1'b1, 8'h00);
    set_pins(8'h00);
    @(negedge clk);
    pin_in = 8'hFF; bus_addr = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6 change not seen first edge", bus_rdata, 8'h00);
    @(negedge clk);
    read_reg(1'b0, v);
    chk("R6 change seen after sync", v, 8'hFF);
    set_pins(8'h11);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds without read", bus_rdata, 8'hFF);
    read_reg(1'b0, v);
    chk("R9 rdata updates on read", v, 8'h11);
  endtask

  initial begin
    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dir();
    t_data();
    t_mixed();
    t_clk();
    t_latency();
    summary();
  end

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end
endmodule